// File: doc/BRIEF.md
# MSI Message Ring Writer

This block sits behind the address decode of message-signalled interrupt writes. Each incoming message carries a data word, and the low 16 bits of that word are an interrupt number. The block formats the number into a fixed 16-byte record and writes the record to a circular buffer in host memory. The buffer is located by a 64-bit base address. A write offset, which the block maintains, gives the position of the next record. Software drains the ring, advances a read offset, and receives a level interrupt while unread records remain.

Software sets the block up through a small register port with address, data and write-enable. That port holds a control word, the two halves of the base address, and the two ring offsets. The control word selects one of four ring sizes. It also selects the policy when the ring is full: either incoming messages are stalled, or they are discarded and a sticky overflow flag records the loss. Records leave the block as single 16-byte beats on a valid/ready memory request port. Only one record is in flight at a time.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset the control word, the read offset and the write offset read as zero, `irqOut` and `memValid` are low, and `msgReady` is low.
- R2: A register write takes effect at the next clock edge. A read returns the selected register one cycle after `regAddr` is presented. The registers sit at these addresses: 0 control, 3 base high, 4 base low, 5 read offset, 6 write offset. Control keeps only bit 0 (enable), bit 1 (overflow signalling), bit 3 (interrupt enable), bit 4 (stall when full) and bits 9:8 (size code). All other written bits read as zero. Bit 16 is the read-only overflow flag. The write offset cannot be written by software.
- R3: Each record is one 128-bit beat. Bits 15:0 hold the message's low 16 bits, bits 31:16 are zero, and bits 127:32 are all ones.
- R4: The record address `memAddr` is {base high, base low} plus the current write offset.
- R5: The write offset advances by 16 only on a cycle where `memValid` and `memReady` are both high. While `memReady` is low, `memValid`, `memAddr` and `memData` hold.
- R6: The ring holds 2^(MIN_SHIFT+code) bytes, where code is control bits 9:8. The write offset wraps from the last record to zero.
- R7: A written read offset is stored with its low 4 bits cleared and its value limited to the ring size. Both offsets are read back in that masked form.
- R8: The ring is full when the advanced write offset would equal the read offset. When the ring is full and stall-when-full is set, `msgReady` is low.
- R9: When the ring is full and stall-when-full is clear, a message is accepted, no memory write is made, and the overflow flag (control bit 16) is set. Writing control with bit 16 set clears the flag.
- R10: `irqOut` is high when the block is enabled, interrupt enable is set, and the write offset differs from the read offset.
- R11: When overflow signalling is set, `irqOut`, gated by enable and interrupt enable, is also high while the overflow flag is set.
- R12: With enable clear, `msgReady` and `irqOut` are low, and the base, size and offset settings keep their values.
- R13: No new message is accepted while a record waits for memory (`memValid` high implies `msgReady` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data for last regAddr |
| msgValid | input | 1 | Incoming message present |
| msgData | input | 32 | Message data word, low 16 bits used |
| msgReady | output | 1 | Message taken this cycle when valid |
| memValid | output | 1 | Record write request |
| memReady | input | 1 | Memory accepts request |
| memAddr | output | 64 | Record byte address |
| memData | output | 128 | Record contents, byte 0 in bits 7:0 |
| irqOut | output | 1 | Level summary interrupt |

## Verification
The bench builds the block with MIN_SHIFT set to 8, so the four size codes give rings of 16, 32, 64 and 128 records rather than thousands. With rings that small, a run can reach the wrap from the last record to zero and fill the ring to the full condition in a few dozen messages. It can then drive both full-ring policies and a size change that moves the wrap point. The memory side stalls two cycles in three, which exercises request hold and the single-record-in-flight rule on every record.

// File: rtl/msi_ring_pkg.sv
`timescale 1ns/1ps
package msi_ring_pkg;

  // register map
  localparam logic [2:0] REG_CTRL    = 3'd0;
  localparam logic [2:0] REG_BASE_HI = 3'd3;
  localparam logic [2:0] REG_BASE_LO = 3'd4;
  localparam logic [2:0] REG_RD_OFF  = 3'd5;
  localparam logic [2:0] REG_WR_OFF  = 3'd6;

  // control bit positions
  localparam int BIT_EN      = 0;
  localparam int BIT_OVF_SIG = 1;
  localparam int BIT_IRQ_EN  = 3;
  localparam int BIT_STOP    = 4;
  localparam int BIT_SIZE_LO = 8;
  localparam int BIT_OVF     = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptStb;  // message captured into the pending record
    logic dropStb;    // message discarded because the ring is full
    logic retireStb;  // pending record taken by memory
  } ringStrobes_t;

endpackage

// File: rtl/msi_ring_ctrl.sv
`timescale 1ns/1ps
module msi_ring_ctrl
  import msi_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         msgValid,
  input  logic         memReady,
  input  logic         enable,
  input  logic         ringFull,
  input  logic         stopOnFull,
  output logic         msgReady,
  output logic         memValid,
  output ringStrobes_t strobes
);

  logic pending;
  logic take;

  // a message is taken only while idle and not stalled by a full ring
  assign msgReady = enable && !pending && !(ringFull && stopOnFull);
  assign take     = msgValid && msgReady;

  always_comb begin
    strobes.acceptStb = take && !ringFull;
    strobes.dropStb   = take && ringFull;
    strobes.retireStb = pending && memReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobes.retireStb) begin
      pending <= 1'b0;
    end else if (strobes.acceptStb) begin
      pending <= 1'b1;
    end
  end

  assign memValid = pending;

endmodule

// File: rtl/msi_ring_dp.sv
`timescale 1ns/1ps
module msi_ring_dp
  import msi_ring_pkg::*;
#(
  parameter int MIN_SHIFT = 15,
  parameter int NUM_W     = 16,
  parameter int REC_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2:0]             regAddr,
  input  logic                   regWrEn,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  logic [NUM_W-1:0]       msgNum,
  input  ringStrobes_t           strobes,
  output logic [63:0]            memAddr,
  output logic [REC_BYTES*8-1:0] memData,
  output logic                   irqOut,
  output logic                   enable,
  output logic                   irqEnable,
  output logic                   stopOnFull,
  output logic                   ringFull
);

  localparam int OFF_W = MIN_SHIFT + 3;
  localparam int MEM_W = REC_BYTES * 8;
  localparam logic [OFF_W-1:0] REC_LOW  = OFF_W'(REC_BYTES - 1);
  localparam logic [OFF_W-1:0] REC_STEP = OFF_W'(REC_BYTES);
  localparam logic [OFF_W-1:0] ALL_ONES = '1;

  logic             ctlEn, ctlOvfSig, ctlIrqEn, ctlStop, overflow;
  logic [1:0]       ctlSize;
  logic [31:0]      baseHi, baseLo;
  logic [OFF_W-1:0] rdOffRaw, wrOffRaw;
  logic [NUM_W-1:0] recNum;

  logic [OFF_W-1:0] sizeMask, rdOff, wrOff, nextWr;
  logic [31:0]      ctrlWord, rdMux;

  // offset mask for the selected ring size, record-aligned
  assign sizeMask = (ALL_ONES >> (2'd3 - ctlSize)) & ~REC_LOW;
  assign rdOff    = rdOffRaw & sizeMask;
  assign wrOff    = wrOffRaw & sizeMask;
  assign nextWr   = (wrOff + REC_STEP) & sizeMask;
  assign ringFull = (nextWr == rdOff);

  assign enable     = ctlEn;
  assign irqEnable  = ctlIrqEn;
  assign stopOnFull = ctlStop;

  // control register and overflow flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlEn     <= 1'b0;
      ctlOvfSig <= 1'b0;
      ctlIrqEn  <= 1'b0;
      ctlStop   <= 1'b0;
      ctlSize   <= 2'd0;
      overflow  <= 1'b0;
    end else begin
      if (regWrEn && regAddr == REG_CTRL) begin
        ctlEn     <= regWrData[BIT_EN];
        ctlOvfSig <= regWrData[BIT_OVF_SIG];
        ctlIrqEn  <= regWrData[BIT_IRQ_EN];
        ctlStop   <= regWrData[BIT_STOP];
        ctlSize   <= regWrData[BIT_SIZE_LO +: 2];
        if (regWrData[BIT_OVF]) overflow <= 1'b0;
      end
      if (strobes.dropStb) overflow <= 1'b1;
    end
  end

  // base address and offsets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi   <= '0;
      baseLo   <= '0;
      rdOffRaw <= '0;
      wrOffRaw <= '0;
    end else begin
      if (regWrEn && regAddr == REG_BASE_HI) baseHi <= regWrData;
      if (regWrEn && regAddr == REG_BASE_LO) baseLo <= regWrData;
      if (regWrEn && regAddr == REG_RD_OFF)
        rdOffRaw <= regWrData[OFF_W-1:0] & ~REC_LOW;
      if (strobes.retireStb) wrOffRaw <= nextWr;
    end
  end

  // pending record contents
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recNum <= '0;
    end else if (strobes.acceptStb) begin
      recNum <= msgNum;
    end
  end

  assign memAddr = {baseHi, baseLo} + {{(64-OFF_W){1'b0}}, wrOff};
  assign memData = {{(MEM_W-32){1'b1}}, {(32-NUM_W){1'b0}}, recNum};

  // read path
  assign ctrlWord = {15'b0, overflow, 6'b0, ctlSize, 3'b0, ctlStop,
                     ctlIrqEn, 1'b0, ctlOvfSig, ctlEn};

  always_comb begin
    case (regAddr)
      REG_CTRL:    rdMux = ctrlWord;
      REG_BASE_HI: rdMux = baseHi;
      REG_BASE_LO: rdMux = baseLo;
      REG_RD_OFF:  rdMux = 32'(rdOff);
      REG_WR_OFF:  rdMux = 32'(wrOff);
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else       regRdData <= rdMux;
  end

  assign irqOut = ctlEn && ctlIrqEn &&
                  ((wrOff != rdOff) || (ctlOvfSig && overflow));

endmodule

// File: rtl/msi_ring_writer.sv
`timescale 1ns/1ps
module msi_ring_writer
  import msi_ring_pkg::*;
#(
  parameter int MIN_SHIFT = 15,
  parameter int NUM_W     = 16,
  parameter int REC_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2:0]             regAddr,
  input  logic                   regWrEn,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  logic                   msgValid,
  input  logic [31:0]            msgData,
  output logic                   msgReady,
  output logic                   memValid,
  input  logic                   memReady,
  output logic [63:0]            memAddr,
  output logic [REC_BYTES*8-1:0] memData,
  output logic                   irqOut
);

  ringStrobes_t strobes;
  logic enBit, irqEnBit, stopBit, fullFlag;
  logic unusedMsgHi;

  assign unusedMsgHi = ^msgData[31:NUM_W];

  msi_ring_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .msgValid   (msgValid),
    .memReady   (memReady),
    .enable     (enBit),
    .ringFull   (fullFlag),
    .stopOnFull (stopBit),
    .msgReady   (msgReady),
    .memValid   (memValid),
    .strobes    (strobes)
  );

  msi_ring_dp #(
    .MIN_SHIFT (MIN_SHIFT),
    .NUM_W     (NUM_W),
    .REC_BYTES (REC_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .msgNum     (msgData[NUM_W-1:0]),
    .strobes    (strobes),
    .memAddr    (memAddr),
    .memData    (memData),
    .irqOut     (irqOut),
    .enable     (enBit),
    .irqEnable  (irqEnBit),
    .stopOnFull (stopBit),
    .ringFull   (fullFlag)
  );

endmodule

// File: rtl/msi_ring_chk.sv
`timescale 1ns/1ps
module msi_ring_chk #(
  parameter int NUM_W = 16,
  parameter int MEM_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             msgReady,
  input logic             memValid,
  input logic             memReady,
  input logic [63:0]      memAddr,
  input logic [MEM_W-1:0] memData,
  input logic             irqOut,
  input logic             enable,
  input logic             irqEnable,
  input logic             ringFull,
  input logic             stopOnFull
);

  a_r13_single_flight: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !msgReady);

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData)));

  a_r3_record_pad: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memData[MEM_W-1:32] == '1 && memData[31:NUM_W] == '0));

  a_r8_stall_full: assert property (@(posedge clk) disable iff (!rstN)
    (ringFull && stopOnFull) |-> !msgReady);

  a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!msgReady && !irqOut));

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irqOut);

endmodule

bind msi_ring_writer msi_ring_chk #(
  .NUM_W (NUM_W),
  .MEM_W (REC_BYTES*8)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .msgReady   (msgReady),
  .memValid   (memValid),
  .memReady   (memReady),
  .memAddr    (memAddr),
  .memData    (memData),
  .irqOut     (irqOut),
  .enable     (enBit),
  .irqEnable  (irqEnBit),
  .ringFull   (fullFlag),
  .stopOnFull (stopBit)
);

// File: tb/sim_msi_ring_writer.sv
`timescale 1ns/1ps
module sim_msi_ring_writer;

  localparam int MIN_SHIFT = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   regAddr = '0;
  logic         regWrEn = 1'b0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         msgValid = 1'b0;
  logic [31:0]  msgData = '0;
  logic         msgReady;
  logic         memValid;
  logic         memReady = 1'b0;
  logic [63:0]  memAddr;
  logic [127:0] memData;
  logic         irqOut;

  msi_ring_writer #(.MIN_SHIFT(MIN_SHIFT)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .msgValid(msgValid),
    .msgData(msgData), .msgReady(msgReady), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memData(memData), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [79:0] expQ[$];
  logic [79:0] item;
  logic [63:0] baseModel = '0;
  logic [31:0] wrModel = '0;
  logic [31:0] rdModel = '0;
  int sizeCode = 0;
  int stallCnt = 0;

  function automatic logic [31:0] ringMask(int code);
    return ((32'd1 << (MIN_SHIFT + code)) - 32'd1) & ~32'hF;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (rstN && memValid) begin
      stallCnt++;
      memReady = (stallCnt % 3) == 0;
      if (memReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected record write", {64'd0, memAddr}, 128'd0);
        end else begin
          item = expQ.pop_front();
          check(memAddr == item[79:16], "R4 record address",
                {64'd0, memAddr}, {64'd0, item[79:16]});
          check(memData == {{96{1'b1}}, 16'h0, item[15:0]}, "R3 record data",
                memData, {{96{1'b1}}, 16'h0, item[15:0]});
        end
      end
    end else begin
      memReady = 1'b0;
    end
  end

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b0;
    @(negedge clk);
    v = regRdData;
  endtask

  task automatic setRead(logic [31:0] v);
    regWrite(3'd5, v);
    rdModel = v & ringMask(sizeCode);
  endtask

  // driver: pushes the expected record, then hands the message over
  task automatic sendMsg(logic [31:0] d, bit expectWrite);
    if (expectWrite) begin
      expQ.push_back({baseModel + 64'(wrModel), d[15:0]});
      wrModel = (wrModel + 32'd16) & ringMask(sizeCode);
    end
    @(negedge clk);
    msgValid = 1'b1; msgData = d;
    #1;
    while (!msgReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    msgValid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (expQ.size() == 0 && !memValid) break;
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5 records drained", 128'(expQ.size()), 128'd0);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog expired", 128'd0, 128'd0);
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(!irqOut && !memValid && !msgReady, "R1 outputs idle",
          {irqOut, memValid, msgReady}, 3'b000);
    regRead(3'd0, v); check(v == 0, "R1 control zero", v, 0);
    regRead(3'd5, v); check(v == 0, "R1 read offset zero", v, 0);
    regRead(3'd6, v); check(v == 0, "R1 write offset zero", v, 0);

    // R2 register storage
    regWrite(3'd3, 32'h1234_5678);
    regWrite(3'd4, 32'hABCD_0000);
    baseModel = 64'h1234_5678_ABCD_0000;
    regRead(3'd3, v); check(v == 32'h1234_5678, "R2 base high", v, 32'h1234_5678);
    regRead(3'd4, v); check(v == 32'hABCD_0000, "R2 base low", v, 32'hABCD_0000);
    regWrite(3'd0, 32'hFFFF_FFFF);
    regRead(3'd0, v); check(v == 32'h31B, "R2 control keeps defined bits", v, 32'h31B);
    regWrite(3'd0, 32'h009);
    sizeCode = 0;
    regWrite(3'd6, 32'h40);
    regRead(3'd6, v); check(v == 0, "R2 write offset not writable", v, 0);

    // R3 R4 R5 records
    sendMsg(32'hDEAD_0011, 1'b1);
    sendMsg(32'h0000_ABCD, 1'b1);
    sendMsg(32'hFFFF_0007, 1'b1);
    drain();
    regRead(3'd6, v); check(v == 32'h30, "R5 offset advanced per record", v, 32'h30);
    check(irqOut, "R10 irq with unread records", irqOut, 1);

    // R10 R7
    setRead(32'h30);
    @(negedge clk);
    check(!irqOut, "R10 irq clears when offsets match", irqOut, 0);
    setRead(32'h1237);
    regRead(3'd5, v); check(v == 32'h30, "R7 read offset masked", v, 32'h30);

    // R6 wrap, then R9 drop with stall-when-full clear
    for (int i = 0; i < 15; i++) sendMsg(32'h100 + 32'(i), 1'b1);
    drain();
    regRead(3'd6, v); check(v == 32'h20, "R6 wrapped write offset", v, 32'h20);
    sendMsg(32'h0BAD, 1'b0);
    drain();
    regRead(3'd6, v); check(v == 32'h20, "R9 dropped record leaves offset", v, 32'h20);
    regRead(3'd0, v); check(v == 32'h10009, "R9 overflow flag set", v, 32'h10009);

    // R11 overflow signalling
    setRead(32'h20);
    @(negedge clk);
    check(!irqOut, "R11 no irq without overflow signalling", irqOut, 0);
    regWrite(3'd0, 32'h00B);
    check(irqOut, "R11 irq from overflow flag", irqOut, 1);
    regWrite(3'd0, 32'h1000B);
    check(!irqOut, "R9 overflow cleared drops irq", irqOut, 0);
    regRead(3'd0, v); check(v == 32'h00B, "R9 overflow flag clear", v, 32'h00B);

    // R8 stall when full
    regWrite(3'd0, 32'h01B);
    for (int i = 0; i < 15; i++) sendMsg(32'h200 + 32'(i), 1'b1);
    drain();
    @(negedge clk);
    msgValid = 1'b1; msgData = 32'h0777;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!msgReady && !memValid, "R8 full ring stalls intake",
            {msgReady, memValid}, 2'b00);
    end
    msgValid = 1'b0;
    setRead(32'h30);
    sendMsg(32'h0777, 1'b1);
    drain();
    regRead(3'd6, v); check(v == 32'h20, "R8 intake resumes after drain", v, 32'h20);

    // R6 larger ring
    regWrite(3'd0, 32'h109);
    sizeCode = 1;
    setRead(32'h10);
    regRead(3'd5, v); check(v == 32'h10, "R7 read offset in larger ring", v, 32'h10);
    setRead(32'h1F0);
    regRead(3'd5, v); check(v == 32'h1F0, "R7 offset beyond small ring kept", v, 32'h1F0);
    setRead(32'h10);
    for (int i = 0; i < 30; i++) sendMsg(32'h300 + 32'(i), 1'b1);
    drain();
    regRead(3'd6, v); check(v == 32'h0, "R6 wrap at larger size", v, 0);

    // R12 disable keeps settings
    regWrite(3'd0, 32'h100);
    @(negedge clk);
    check(!msgReady && !irqOut, "R12 disabled is quiet", {msgReady, irqOut}, 2'b00);
    regRead(3'd0, v); check(v == 32'h100, "R12 size kept", v, 32'h100);
    regRead(3'd3, v); check(v == 32'h1234_5678, "R12 base high kept", v, 32'h1234_5678);
    regRead(3'd4, v); check(v == 32'hABCD_0000, "R12 base low kept", v, 32'hABCD_0000);
    regRead(3'd5, v); check(v == 32'h10, "R12 read offset kept", v, 32'h10);
    regRead(3'd6, v); check(v == 32'h0, "R12 write offset kept", v, 0);

    summary();
  end

endmodule